// File: doc/BRIEF.md
# Fine-Grain Multithreaded Issue Selector

This block is the issue stage of a SIMD control unit that keeps a set of hardware thread contexts (16 by default). On every clock edge it looks at which threads hold a pending instruction and picks one of them in round-robin order. The chosen instruction goes out on exactly one of three paths. Scalar work stays in the control unit. Broadcast/parallel work goes to the PE array over the broadcast network. Reduction work uses the broadcast network and also the combining network. Because the unit moves to a different thread on every cycle, and threads do not depend on each other's data, independent threads fill the cycles a single thread would spend waiting for a slow reduction.

Each thread context is a two-state machine. In `TS_FREE` the thread may issue whenever its instruction-valid input is high. Transition `ISSUE_REDUCE` moves it to `TS_HELD` when the thread is granted a reduction. Transition `RESUME` returns it to `TS_FREE` when a completion pulse arrives carrying that thread's ID. The issue outputs are registered, so a grant made on one clock edge appears on the outputs until the next edge. Fetch, the register files and the PE array sit outside this block.

Top module: `mt_issue_top`

## Requirements
- R1: After reset, all threads are in `TS_FREE`, every output is low, and the search start pointer is thread 0. The first grant with all threads ready therefore goes to thread 0.
- R2: At each clock edge at most one thread is granted. A thread is eligible only if its valid bit is high, it is in `TS_FREE`, and its class code is not reserved. The grant shows on `iss_vld`/`iss_tid`/`iss_cls` and the path strobes until the next edge.
- R3: The search starts at the thread after the last granted one, wraps modulo the thread count, and skips threads that are not eligible.
- R4: Class code 2'b00 is scalar and raises only `scl_vld`. Code 2'b01 is broadcast/parallel and raises only `bcst_vld`. Code 2'b10 is reduction and raises only `red_vld`. Exactly one strobe is high when `iss_vld` is high, and none is high otherwise.
- R5: A thread granted a reduction enters `TS_HELD` on the same edge and is not granted again while held.
- R6: A completion pulse whose thread ID names a held thread returns that thread to `TS_FREE`. The thread can be granted at the next edge.
- R7: A completion pulse that names a thread in `TS_FREE` has no effect. This includes a thread that is granted a reduction on that same edge: the thread still enters `TS_HELD`.
- R8: When no thread is eligible, the unit issues a bubble: `iss_vld` and all strobes are low, and the start pointer keeps its value.
- R9: Class code 2'b11 is reserved. A thread presenting it is not eligible and is skipped.
- R10: While some threads are held, the remaining eligible threads continue to be granted every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_inst_vld | input | NUM_THR | Per-thread pending-instruction flag |
| thr_inst_cls | input | 2*NUM_THR | Per-thread class code; thread t uses bits [2t+1:2t] |
| red_done | input | 1 | Reduction completion pulse |
| red_done_tid | input | TID_W | Thread ID carried by the completion pulse |
| iss_vld | output | 1 | An instruction was issued this cycle |
| iss_tid | output | TID_W | ID of the issuing thread |
| iss_cls | output | 2 | Class code of the issued instruction |
| scl_vld | output | 1 | Scalar path strobe |
| bcst_vld | output | 1 | Broadcast/parallel path strobe |
| red_vld | output | 1 | Reduction path strobe |

## Verification
The assertions assume that a completion pulse lasts one cycle. They also assume that a thread's valid and class inputs are stable from the negative edge before a sampling edge through that edge, since the grant is taken from the values sampled at the edge. The bench changes every input only on the falling clock edge and pulses `red_done` for a single cycle. The bench also deliberately sends a completion for a thread that is not held, so that R7 is exercised within these assumptions.

// File: rtl/mt_issue_pkg.sv
package mt_issue_pkg;

    // Instruction class codes carried per thread.
    typedef enum logic [1:0] {
        IC_SCALAR = 2'b00,
        IC_BCAST  = 2'b01,
        IC_REDUCE = 2'b10,
        IC_RSVD   = 2'b11
    } icls_e;

    // Per-thread issue permission state.
    typedef enum logic {
        TS_FREE = 1'b0,
        TS_HELD = 1'b1
    } tstate_e;

endpackage

// File: rtl/mt_thr_ctx.sv
module mt_thr_ctx
    import mt_issue_pkg::*;
#(
    parameter int TID_W  = 4,
    parameter int THR_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_vld,
    input  logic [1:0]       inst_cls,
    input  logic             granted,
    input  logic             done_pls,
    input  logic [TID_W-1:0] done_tid,
    output logic             ready,
    output logic             held
);

    localparam logic [TID_W-1:0] MY_TID = TID_W'(THR_ID);

    tstate_e st_q, st_d;
    logic    done_hit;
    logic    take_red;

    assign done_hit = done_pls && (done_tid == MY_TID);
    assign take_red = granted && (icls_e'(inst_cls) == IC_REDUCE);

    // Next-state: ISSUE_REDUCE and RESUME transitions.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_FREE: if (take_red) st_d = TS_HELD;
            TS_HELD: if (done_hit) st_d = TS_FREE;
            default: st_d = TS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_FREE;
        else        st_q <= st_d;
    end

    // Outputs.
    always_comb begin
        ready = 1'b0;
        held  = 1'b0;
        unique case (st_q)
            TS_FREE: ready = inst_vld && (icls_e'(inst_cls) != IC_RSVD);
            TS_HELD: held  = 1'b1;
            default: ready = 1'b0;
        endcase
    end

    // R5: a granted reduction puts the thread on hold.
    a_r5_reduce_holds: assert property (@(posedge clk) disable iff (!rst_n)
        take_red |=> (st_q == TS_HELD));

    // R6: a completion addressed to a held thread frees it.
    a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_HELD && done_hit) |=> (st_q == TS_FREE));

    // R5: a held thread is never granted.
    a_r5_no_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_HELD) |-> !granted);

endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
    parameter int NUM_THR = 16,
    parameter int TID_W   = 4
) (
    input  logic [NUM_THR-1:0] req,
    input  logic [TID_W-1:0]   start,
    output logic               gnt_vld,
    output logic [TID_W-1:0]   gnt_tid
);

    // Scan from start upward with wrap; the lowest offset wins because it is written last.
    always_comb begin
        int j;
        gnt_vld = 1'b0;
        gnt_tid = '0;
        for (int i = NUM_THR - 1; i >= 0; i--) begin
            j = int'(start) + i;
            if (j >= NUM_THR) j = j - NUM_THR;
            if (req[j]) begin
                gnt_vld = 1'b1;
                gnt_tid = TID_W'(j);
            end
        end
    end

endmodule

// File: rtl/mt_issue_top.sv
module mt_issue_top
    import mt_issue_pkg::*;
#(
    parameter int NUM_THR = 16,
    parameter int TID_W   = $clog2(NUM_THR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_THR-1:0]   thr_inst_vld,
    input  logic [2*NUM_THR-1:0] thr_inst_cls,
    input  logic                 red_done,
    input  logic [TID_W-1:0]     red_done_tid,
    output logic                 iss_vld,
    output logic [TID_W-1:0]     iss_tid,
    output logic [1:0]           iss_cls,
    output logic                 scl_vld,
    output logic                 bcst_vld,
    output logic                 red_vld
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THR - 1);

    logic [NUM_THR-1:0] rdy_vec;
    logic [NUM_THR-1:0] held_vec;
    logic               gnt_vld;
    logic [TID_W-1:0]   gnt_tid;
    logic [TID_W-1:0]   start_q;
    logic [1:0]         gnt_cls;

    // Per-thread contexts.
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        mt_thr_ctx #(
            .TID_W (TID_W),
            .THR_ID(t)
        ) ctx_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .inst_vld(thr_inst_vld[t]),
            .inst_cls(thr_inst_cls[2*t +: 2]),
            .granted (gnt_vld && (gnt_tid == TID_W'(t))),
            .done_pls(red_done),
            .done_tid(red_done_tid),
            .ready   (rdy_vec[t]),
            .held    (held_vec[t])
        );
    end

    mt_rr_pick #(
        .NUM_THR(NUM_THR),
        .TID_W  (TID_W)
    ) pick_i (
        .req    (rdy_vec),
        .start  (start_q),
        .gnt_vld(gnt_vld),
        .gnt_tid(gnt_tid)
    );

    assign gnt_cls = thr_inst_cls[2*gnt_tid +: 2];

    // Issue register and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            iss_vld <= 1'b0;
            iss_tid <= '0;
            iss_cls <= IC_SCALAR;
        end else begin
            iss_vld <= gnt_vld;
            if (gnt_vld) begin
                iss_tid <= gnt_tid;
                iss_cls <= gnt_cls;
                start_q <= (gnt_tid == LAST_TID) ? '0 : gnt_tid + 1'b1;
            end
        end
    end

    // Path strobes.
    always_comb begin
        scl_vld  = 1'b0;
        bcst_vld = 1'b0;
        red_vld  = 1'b0;
        if (iss_vld) begin
            unique case (icls_e'(iss_cls))
                IC_SCALAR: scl_vld  = 1'b1;
                IC_BCAST:  bcst_vld = 1'b1;
                IC_REDUCE: red_vld  = 1'b1;
                default:   scl_vld  = 1'b0;
            endcase
        end
    end

    // R2: an issued thread was eligible at the edge that chose it.
    a_r2_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> ((($past(rdy_vec)) >> iss_tid) & NUM_THR'(1)) != '0);

    // R4: exactly one path strobe per issued instruction.
    a_r4_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_vld, bcst_vld, red_vld}) && ((scl_vld | bcst_vld | red_vld) == iss_vld));

    // R5: the thread behind a reduction strobe is already held.
    a_r5_red_thread_held: assert property (@(posedge clk) disable iff (!rst_n)
        red_vld |-> held_vec[iss_tid]);

    // R5: no back-to-back issue from a thread that just sent a reduction.
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        red_vld |=> !(iss_vld && iss_tid == $past(iss_tid)));

    // R9: reserved code never reaches the outputs.
    a_r9_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> (icls_e'(iss_cls) != IC_RSVD));

    // R8: pointer holds across a bubble.
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld |=> $stable(start_q));

endmodule

// File: tb/mt_issue_top_tb_top.sv
`timescale 1ns/1ps
module mt_issue_top_tb_top;

    localparam int N  = 16;
    localparam int TW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    vld = '0;
    logic [2*N-1:0]  cls = '0;
    logic            done = 1'b0;
    logic [TW-1:0]   done_tid = '0;
    logic            iss_vld;
    logic [TW-1:0]   iss_tid;
    logic [1:0]      iss_cls;
    logic            scl_vld, bcst_vld, red_vld;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    // Bench-side expectation state derived from the requirements.
    logic [N-1:0] m_blk = '0;
    int           m_ptr = 0;

    always #4 clk = ~clk;

    mt_issue_top #(.NUM_THR(N), .TID_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .thr_inst_vld(vld), .thr_inst_cls(cls),
        .red_done(done), .red_done_tid(done_tid),
        .iss_vld(iss_vld), .iss_tid(iss_tid), .iss_cls(iss_cls),
        .scl_vld(scl_vld), .bcst_vld(bcst_vld), .red_vld(red_vld)
    );

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: inputs already set at a negedge; compare after the next negedge.
    task automatic step(input string tag);
        int g;
        int c;
        logic [N-1:0] pre_blk;
        logic [2:0] exp_s;
        g = -1;
        c = 0;
        pre_blk = m_blk;
        for (int i = 0; i < N; i++) begin
            int j;
            j = (m_ptr + i) % N;
            if (g < 0 && vld[j] && !m_blk[j] && cls[2*j +: 2] != 2'b11) g = j;
        end
        @(posedge clk);
        if (g >= 0) begin
            c = int'(cls[2*g +: 2]);
            m_ptr = (g + 1) % N;
            if (c == 2) m_blk[g] = 1'b1;
        end
        if (done && pre_blk[done_tid]) m_blk[done_tid] = 1'b0;
        @(negedge clk);
        chk({tag, " vld"}, iss_vld == (g >= 0), int'(iss_vld), int'(g >= 0));
        exp_s = (g < 0) ? 3'b000 : (c == 0) ? 3'b100 : (c == 1) ? 3'b010 : 3'b001;
        chk({tag, " strobes"}, {scl_vld, bcst_vld, red_vld} == exp_s,
            int'({scl_vld, bcst_vld, red_vld}), int'(exp_s));
        if (g >= 0) begin
            chk({tag, " tid"}, int'(iss_tid) == g, int'(iss_tid), g);
            chk({tag, " cls"}, int'(iss_cls) == c, int'(iss_cls), c);
        end
    endtask

    task automatic t_reset();
        chk("R1 reset vld", iss_vld == 1'b0, int'(iss_vld), 0);
        chk("R1 reset strobes", {scl_vld, bcst_vld, red_vld} == 3'b000,
            int'({scl_vld, bcst_vld, red_vld}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        vld = '1;
        cls = '0;
        step("R1 first grant");
        chk("R1 first tid is 0", iss_tid == '0, int'(iss_tid), 0);
    endtask

    task automatic t_rr_scalar();
        for (int k = 0; k < 18; k++) step("R3 rr scalar");
        cls = {N{2'b01}};
        for (int k = 0; k < 4; k++) step("R2 rr bcast");
    endtask

    task automatic t_sparse();
        vld = '0;
        vld[3] = 1'b1; vld[9] = 1'b1; vld[14] = 1'b1;
        cls = '0;
        for (int k = 0; k < 7; k++) step("R3 skip");
    endtask

    task automatic t_mixed();
        vld = '1;
        for (int t = 0; t < N; t++) cls[2*t +: 2] = 2'(t % 3);
        for (int k = 0; k < 24; k++) step("R10 mixed");
        chk("R5 held count", m_blk != '0, int'(m_blk), 1);
    endtask

    task automatic t_bubble();
        vld = '0;
        for (int k = 0; k < 3; k++) step("R8 bubble");
        vld = '1;
        cls = '0;
        step("R8 ptr kept");
    endtask

    task automatic t_release();
        vld = '1;
        for (int t = 0; t < N; t++) cls[2*t +: 2] = 2'b10;
        for (int t = 0; t < N; t++) begin
            if (m_blk[t]) begin
                done = 1'b1;
                done_tid = TW'(t);
                step("R6 release");
                done = 1'b0;
                step("R6 after release");
            end
        end
        for (int k = 0; k < 3; k++) step("R8 all held");
        for (int t = 0; t < N; t++) begin
            done = 1'b1;
            done_tid = TW'(t);
            vld = '0;
            step("R6 drain");
        end
        done = 1'b0;
        // R7: completion for a free thread granted a reduction on the same edge.
        vld = '0;
        vld[1] = 1'b1;
        done = 1'b1;
        done_tid = TW'(1);
        step("R7 spurious same edge");
        done = 1'b0;
        step("R7 still held");
        chk("R7 no reissue", iss_vld == 1'b0, int'(iss_vld), 0);
        done = 1'b1;
        done_tid = TW'(1);
        step("R6 proper done");
        done = 1'b0;
        step("R6 reissue");
        chk("R6 thread 1 back", iss_vld && iss_tid == TW'(1), int'(iss_tid), 1);
        done = 1'b1;
        done_tid = TW'(1);
        vld = '0;
        step("R6 final done");
        done = 1'b0;
    endtask

    task automatic t_rsvd();
        vld = '1;
        cls = {N{2'b11}};
        cls[2*5 +: 2] = 2'b00;
        cls[2*12 +: 2] = 2'b01;
        for (int k = 0; k < 5; k++) step("R9 reserved");
        cls = {N{2'b11}};
        step("R9 all reserved");
        chk("R9 bubble", iss_vld == 1'b0, int'(iss_vld), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_rr_scalar();
        t_sparse();
        t_mixed();
        t_bubble();
        t_release();
        t_rsvd();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule